// File: doc/BRIEF.md
# Processor Interrupt Acknowledge and Completion Port

This block holds the interrupt state that belongs to one processor of a multi-source interrupt controller. Each source has a priority, a vector and a sense bit (level or edge), which a configuration interface supplies. When a source asks for delivery, the block records it as waiting if its priority is above the processor's task priority. It keeps a set of waiting sources, a set of in-service sources and an activity bit per source. From these it drives a level interrupt line to the processor.

Software uses a small register port. Reading the acknowledge register returns the vector of the best waiting source and moves that source into service. It returns the spurious vector instead when nothing is waiting, or when the chosen source has gone stale. Writing the completion register retires the best in-service source, which lets lower-priority work reach the processor again. The port also holds the task priority and the spurious vector, and reports the processor index.

Top module: `cpuport_unit`

## Requirements
- R1: After reset, the task priority reads 0xF, the spurious vector reads 0xFF, the waiting and in-service sets are empty and `irq_o` is low.
- R2: A request (`req_valid`, `req_src`) is accepted only if the source priority is strictly above the task priority. Acceptance sets the source's waiting bit and activity bit. A source of priority 0 is never accepted.
- R3: A request for a source whose waiting bit is already set is dropped. It leaves no second entry behind.
- R4: The candidate is the waiting source with the largest priority. Among equal priorities the lowest source number wins. Source i takes priority bits [4i+3:4i] of `src_prio`, vector bits [8i+7:8i] of `src_vec` and sense bit i of `src_level` (1 = level, 0 = edge).
- R5: `irq_o` is high in a cycle exactly when a candidate exists and its priority is above both the task priority and the largest in-service priority. An empty in-service set counts as below every priority. `irq_o` is computed from the registered state.
- R6: A read of the acknowledge register (address 2) with no waiting source returns the spurious vector, zero-extended, and changes no state.
- R7: If the candidate is no longer active, or its priority is no longer above the task priority, an acknowledge read returns the spurious vector. It also clears the candidate's waiting bit and activity bit and does not put the source into service.
- R8: Otherwise an acknowledge read returns the candidate's vector, zero-extended. It clears the candidate's waiting bit and sets its in-service bit. For an edge source it also clears the activity bit. A request accepted in the same cycle is kept.
- R9: A level drop (`drop_valid`, `drop_src`) clears the activity bit of a level source and has no effect on an edge source.
- R10: A write to the completion register (address 3) clears the in-service bit of the in-service source with the largest priority, the lowest number on a tie. A read of address 3 returns 0.
- R11: A read of the identity register (address 1) returns `CPU_IDX`. Writes to addresses 1 and 2 change no state.
- R12: Address 0 holds the task priority and address 4 the spurious vector. A write keeps the low 4 bits or the low 8 bits respectively, and a read returns them zero-extended. Other addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Delivery request strobe |
| req_src | input | SRC_W | Source number of the request |
| drop_valid | input | 1 | Level-drop strobe |
| drop_src | input | SRC_W | Source whose level input went low |
| src_prio | input | N_SRC*PRIO_W | Per-source priorities |
| src_vec | input | N_SRC*VEC_W | Per-source vectors |
| src_level | input | N_SRC | Per-source sense, 1 = level |
| reg_rd | input | 1 | Register read strobe (side effects at the clock edge) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of `reg_rd` |
| irq_o | output | 1 | Interrupt level to the processor |

## Verification
The bench nests a priority-12 source over a priority-9 one in service. It then checks that each completion retires the higher entry first. A design that retired in arrival order, or named the wrong entry, would reopen `irq_o` too early or hand back the wrong vector. A raised task priority and a level drop each turn a waiting source stale. A design that skipped the acknowledge-time recheck would deliver a real vector where the spurious one is due. It also hits equal-priority ties, repeated requests, priority-0 sources, edge sources that ignore a drop, and a request landing in the same cycle as an acknowledge. Errors there would show up as a wrong winner, a duplicate or lost entry, or a vanished interrupt.

// File: rtl/cpuport_pkg.sv
package cpuport_pkg;
  localparam int REG_AW = 3;
  localparam int DATA_W = 32;

  typedef enum logic [REG_AW-1:0] {
    SEL_TASK  = 3'd0,
    SEL_IDENT = 3'd1,
    SEL_ACK   = 3'd2,
    SEL_EOI   = 3'd3,
    SEL_SPUR  = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/cpuport_pick.sv
module cpuport_pick #(
  parameter int N  = 8,
  parameter int PW = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    set_i,
  input  logic [N*PW-1:0] prio_i,
  output logic            found_o,
  output logic [IW-1:0]   idx_o,
  output logic [PW-1:0]   prio_o
);
  // Strict compare while scanning upward: lowest index keeps a tie.
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    prio_o  = '0;
    for (int i = 0; i < N; i++) begin
      if (set_i[i] && (!found_o || (prio_i[i*PW +: PW] > prio_o))) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
        prio_o  = prio_i[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/cpuport_ctrl_regs.sv
module cpuport_ctrl_regs #(
  parameter int PW = 4,
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic          task_we,
  input  logic          spur_we,
  input  logic [31:0]   wdata,
  output logic [PW-1:0] task_q,
  output logic [VW-1:0] spur_q
);
  logic [PW-1:0] task_d;
  logic [VW-1:0] spur_d;

  always_comb begin
    task_d = task_q;
    spur_d = spur_q;
    if (task_we) task_d = wdata[PW-1:0];
    if (spur_we) spur_d = wdata[VW-1:0];
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      task_q <= '1;
      spur_q <= '1;
    end else begin
      if (task_we) task_q <= task_d;
      if (spur_we) spur_q <= spur_d;
    end
  end
endmodule

// File: rtl/cpuport_unit.sv
module cpuport_unit
  import cpuport_pkg::*;
#(
  parameter int N_SRC   = 8,
  parameter int PRIO_W  = 4,
  parameter int VEC_W   = 8,
  parameter int CPU_IDX = 0,
  localparam int SRC_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [SRC_W-1:0]          req_src,
  input  logic                      drop_valid,
  input  logic [SRC_W-1:0]          drop_src,
  input  logic [N_SRC*PRIO_W-1:0]   src_prio,
  input  logic [N_SRC*VEC_W-1:0]    src_vec,
  input  logic [N_SRC-1:0]          src_level,
  input  logic                      reg_rd,
  input  logic                      reg_wr,
  input  logic [REG_AW-1:0]         reg_addr,
  input  logic [DATA_W-1:0]         reg_wdata,
  output logic [DATA_W-1:0]         reg_rdata,
  output logic                      irq_o
);
  logic [1:0]        rst_sync;
  logic              srst_n;
  logic [N_SRC-1:0]  pend_q, pend_d, act_q, act_d, svc_q, svc_d;
  logic [PRIO_W-1:0] task_q;
  logic [VEC_W-1:0]  spur_q;
  logic              pend_found, svc_found;
  logic [SRC_W-1:0]  pend_idx, svc_idx;
  logic [PRIO_W-1:0] pend_prio, svc_prio;
  logic              accept, ack_hit, cand_live, eoi_hit, req_ok, drop_ok;

  // Reset asserts at once and releases after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign srst_n = rst_sync[1];

  cpuport_ctrl_regs #(.PW(PRIO_W), .VW(VEC_W)) u_regs (
    .clk     (clk),
    .srst_n  (srst_n),
    .task_we (reg_wr && (reg_addr == SEL_TASK)),
    .spur_we (reg_wr && (reg_addr == SEL_SPUR)),
    .wdata   (reg_wdata),
    .task_q  (task_q),
    .spur_q  (spur_q)
  );

  cpuport_pick #(.N(N_SRC), .PW(PRIO_W)) u_pick_pend (
    .set_i(pend_q), .prio_i(src_prio),
    .found_o(pend_found), .idx_o(pend_idx), .prio_o(pend_prio)
  );

  cpuport_pick #(.N(N_SRC), .PW(PRIO_W)) u_pick_svc (
    .set_i(svc_q), .prio_i(src_prio),
    .found_o(svc_found), .idx_o(svc_idx), .prio_o(svc_prio)
  );

  assign req_ok    = int'(req_src) < N_SRC;
  assign drop_ok   = int'(drop_src) < N_SRC;
  assign accept    = req_valid && req_ok && !pend_q[req_src] &&
                     (src_prio[req_src*PRIO_W +: PRIO_W] > task_q);
  assign ack_hit   = reg_rd && (reg_addr == SEL_ACK) && pend_found;
  assign cand_live = act_q[pend_idx] && (pend_prio > task_q);
  assign eoi_hit   = reg_wr && (reg_addr == SEL_EOI) && svc_found;

  // Next state: clears first, then the new acceptance.
  always_comb begin
    pend_d = pend_q;
    act_d  = act_q;
    svc_d  = svc_q;
    if (drop_valid && drop_ok && src_level[drop_src]) act_d[drop_src] = 1'b0;
    if (ack_hit) begin
      pend_d[pend_idx] = 1'b0;
      if (!cand_live || !src_level[pend_idx]) act_d[pend_idx] = 1'b0;
      if (cand_live) svc_d[pend_idx] = 1'b1;
    end
    if (eoi_hit) svc_d[svc_idx] = 1'b0;
    if (accept) begin
      pend_d[req_src] = 1'b1;
      act_d[req_src]  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      pend_q <= '0;
      act_q  <= '0;
      svc_q  <= '0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
      svc_q  <= svc_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      SEL_TASK:  reg_rdata = DATA_W'(task_q);
      SEL_IDENT: reg_rdata = DATA_W'(CPU_IDX);
      SEL_ACK: begin
        if (pend_found && cand_live) reg_rdata = DATA_W'(src_vec[pend_idx*VEC_W +: VEC_W]);
        else                         reg_rdata = DATA_W'(spur_q);
      end
      SEL_SPUR:  reg_rdata = DATA_W'(spur_q);
      default:   reg_rdata = '0;
    endcase
  end

  assign irq_o = pend_found && (pend_prio > task_q) &&
                 (!svc_found || (pend_prio > svc_prio));
endmodule

// File: rtl/cpuport_unit_chk.sv
module cpuport_unit_chk #(
  parameter int N_SRC  = 8,
  parameter int PRIO_W = 4,
  parameter int VEC_W  = 8
) (
  input logic              clk,
  input logic              srst_n,
  input logic              reg_rd,
  input logic              reg_wr,
  input logic [2:0]        reg_addr,
  input logic [31:0]       reg_rdata,
  input logic              req_valid,
  input logic              irq_o,
  input logic [N_SRC-1:0]  pend_q,
  input logic [N_SRC-1:0]  svc_q,
  input logic [PRIO_W-1:0] task_q,
  input logic [VEC_W-1:0]  spur_q
);
  p_irq_needs_pend_r5: assert property (@(posedge clk) disable iff (!srst_n)
    irq_o |-> (pend_q != '0));

  p_empty_ack_spur_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (reg_rd && reg_addr == 3'd2 && pend_q == '0) |-> (reg_rdata == 32'(spur_q)));

  p_ack_takes_one_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (reg_rd && reg_addr == 3'd2 && pend_q != '0 && !req_valid)
      |=> ($countones(pend_q) + 1 == $past($countones(pend_q))));

  p_eoi_retires_one_r10: assert property (@(posedge clk) disable iff (!srst_n)
    (reg_wr && reg_addr == 3'd3 && svc_q != '0)
      |=> ($countones(svc_q) + 1 == $past($countones(svc_q))));

  p_eoi_reads_zero_r10: assert property (@(posedge clk) disable iff (!srst_n)
    (reg_rd && reg_addr == 3'd3) |-> (reg_rdata == 32'd0));

  p_task_only_by_write_r12: assert property (@(posedge clk) disable iff (!srst_n)
    !(reg_wr && reg_addr == 3'd0) |=> $stable(task_q));
endmodule

bind cpuport_unit cpuport_unit_chk #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .srst_n(srst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .req_valid(req_valid),
  .irq_o(irq_o), .pend_q(pend_q), .svc_q(svc_q), .task_q(task_q), .spur_q(spur_q)
);

// File: tb/cpuport_unit_tb.sv
module cpuport_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 8;
  localparam int CPU = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, drop_valid, reg_rd, reg_wr;
  logic [2:0] req_src, drop_src, reg_addr;
  logic [NS*4-1:0] src_prio;
  logic [NS*8-1:0] src_vec;
  logic [NS-1:0] src_level;
  logic [31:0] reg_wdata, reg_rdata;
  logic irq_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int cfg_prio [NS] = '{3, 5, 5, 9, 0, 12, 7, 9};
  int cfg_vec  [NS];
  bit cfg_lvl  [NS];

  bit m_pend [NS];
  bit m_act  [NS];
  bit m_svc  [NS];
  int m_task, m_spur;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpuport_unit #(.N_SRC(NS), .PRIO_W(4), .VEC_W(8), .CPU_IDX(CPU)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src(req_src),
    .drop_valid(drop_valid), .drop_src(drop_src), .src_prio(src_prio),
    .src_vec(src_vec), .src_level(src_level), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  function automatic int best_of(input bit s [NS]);
    int r = -1;
    for (int i = 0; i < NS; i++)
      if (s[i] && (r < 0 || cfg_prio[i] > cfg_prio[r])) r = i;
    return r;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: drive at the falling edge, compare, advance the model, wait an edge.
  task automatic cyc(input bit rv, input int rs, input bit dv, input int ds,
                     input bit rd, input bit wr, input int a, input int wd, input string tag);
    int bp, bs, exp_rd, exp_irq;
    bit live, acc;
    req_valid = rv; req_src = 3'(rs); drop_valid = dv; drop_src = 3'(ds);
    reg_rd = rd; reg_wr = wr; reg_addr = 3'(a); reg_wdata = wd;
    #1;
    bp = best_of(m_pend);
    bs = best_of(m_svc);
    exp_irq = (bp >= 0 && cfg_prio[bp] > m_task && (bs < 0 || cfg_prio[bp] > cfg_prio[bs])) ? 1 : 0;
    check("R5 irq level", int'(irq_o), exp_irq);
    live = (bp >= 0) && m_act[bp] && (cfg_prio[bp] > m_task);
    case (a)
      0: exp_rd = m_task;
      1: exp_rd = CPU;
      2: exp_rd = live ? cfg_vec[bp] : m_spur;
      4: exp_rd = m_spur;
      default: exp_rd = 0;
    endcase
    if (rd) check(tag, int'(reg_rdata), exp_rd);
    acc = rv && !m_pend[rs] && (cfg_prio[rs] > m_task);
    if (dv && cfg_lvl[ds]) m_act[ds] = 0;
    if (rd && a == 2 && bp >= 0) begin
      m_pend[bp] = 0;
      if (!live || !cfg_lvl[bp]) m_act[bp] = 0;
      if (live) m_svc[bp] = 1;
    end
    if (wr && a == 3 && bs >= 0) m_svc[bs] = 0;
    if (wr && a == 0) m_task = wd & 15;
    if (wr && a == 4) m_spur = wd & 255;
    if (acc) begin m_pend[rs] = 1; m_act[rs] = 1; end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input string tag);            cyc(0,0,0,0,0,0,0,0,tag); endtask
  task automatic rd(input int a, input string tag); cyc(0,0,0,0,1,0,a,0,tag); endtask
  task automatic wr(input int a, input int d, input string tag); cyc(0,0,0,0,0,1,a,d,tag); endtask
  task automatic req(input int s, input string tag); cyc(1,s,0,0,0,0,0,0,tag); endtask
  task automatic drop(input int s, input string tag); cyc(0,0,1,s,0,0,0,0,tag); endtask

  initial begin
    for (int i = 0; i < NS; i++) begin
      cfg_vec[i] = 'h40 + i;
      cfg_lvl[i] = (i == 2 || i == 5);
      src_prio[i*4 +: 4] = 4'(cfg_prio[i]);
      src_vec[i*8 +: 8]  = 8'(cfg_vec[i]);
      src_level[i]       = cfg_lvl[i];
      m_pend[i] = 0; m_act[i] = 0; m_svc[i] = 0;
    end
    m_task = 15; m_spur = 255;
    req_valid = 0; req_src = 0; drop_valid = 0; drop_src = 0;
    reg_rd = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 irq in reset", int'(irq_o), 0);
    @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);

    rd(0, "R1 task reset"); rd(4, "R1 spur reset"); rd(1, "R11 ident"); rd(3, "R10 eoi read");
    rd(6, "R12 unused addr");
    req(3, "R2 below task"); rd(2, "R6 empty ack");
    wr(0, 'h13, "R12"); rd(0, "R12 task width");
    wr(4, 'h1A5, "R12"); rd(4, "R12 spur width");
    req(4, "R2 prio zero"); rd(2, "R6 empty ack");
    req(3, "R2 accept"); idle("R5");
    req(3, "R3 repeat"); req(7, "R4 tie"); req(1, "R4");
    rd(2, "R4 tie lowest"); idle("R5 masked by service");
    req(5, "R5 nest"); idle("R5");
    rd(2, "R8 nested ack"); idle("R5");
    wr(3, 0, "R10 retire top"); rd(3, "R10 eoi read");
    wr(3, 0, "R10 retire next"); idle("R5 reopened");
    wr(2, 'h55, "R11 ack write"); wr(1, 7, "R11 ident write");
    rd(0, "R11 task kept"); rd(1, "R11 ident"); rd(2, "R11 ack after ignored write");
    wr(0, 6, "R7 raise task"); idle("R5");
    rd(2, "R7 stale by task"); rd(2, "R6 empty after stale");
    wr(3, 0, "R10"); wr(0, 3, "R12");
    req(2, "R9 level"); drop(2, "R9 level drop"); rd(2, "R7 stale inactive");
    req(6, "R9 edge"); drop(6, "R9 edge drop ignored"); rd(2, "R9 edge live");
    req(5, "R8"); cyc(1, 1, 0, 0, 1, 0, 2, 0, "R8 ack with request");
    rd(2, "R8 kept request");
    wr(3, 0, "R10"); wr(3, 0, "R10"); wr(3, 0, "R10"); idle("R5");

    begin
      int lf = 'h5A3;
      for (int k = 0; k < 400; k++) begin
        int op;
        lf = ((lf << 1) | (((lf >> 10) ^ (lf >> 8)) & 1)) & 'h7FF;
        op = lf & 7;
        case (op)
          0, 1: req((lf >> 3) & 7, "R4 mix");
          2: drop((lf >> 3) & 7, "R9 mix");
          3, 4: rd(2, "R8 mix");
          5: wr(3, 0, "R10 mix");
          6: wr(0, (lf >> 3) & 7, "R12 mix");
          default: cyc(1, (lf >> 4) & 7, 0, 0, 1, 0, 2, 0, "R8 mix");
        endcase
      end
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule